// File: doc/BRIEF.md
# Sideband Thermal Bus Host Register Front End

This block is the processor-side register file and byte FIFO front end of a single-wire sideband host controller used for processor thermal and management queries. Software reaches it through a small synchronous register bus with a 4-bit address, separate write and read strobes, and byte-wide data. Writes to the data register load a transmit FIFO, and the transaction engine drains that FIFO. The engine fills a receive FIFO, and software drains it by reading the same data register.

The block keeps the controller's status and error state and merges it into a single interrupt line. The end-of-frame flag is sticky. The error flags are cleared by writing 1 to them. The FIFO level flags and the bus-idle flag are live. The block also drives the engine's control lines: power-down, a soft-reset pulse, FIFO reset, a gated transmit enable, and the 16-bit bit-time divisor. Software sets the divisor to the core clock in kHz divided by the bitrate, and the core clock is at most 48000 kHz. The wire-level signalling and the pad are outside this block.

Top module: `peci_host_regs`

## Requirements
- R1: After reset, CTRL, STAT1, ERR, both interrupt-enable registers and both divisor bytes read 0. `bit_time_o` is 0 and `irq_o` is 0. With `bus_idle_i` high, STAT2 reads 0x0D.
- R2: Register addresses are DATA=0, CTRL=1, STAT1=2, STAT2=3, ERR=4, IEN1=5, IEN2=6, BT_LO=7 and BT_HI=8. Every register that holds a value reads back what was written. `bit_time_o` is {BT_HI, BT_LO}. Read data appears on `rdata_o` one cycle after the read strobe and stays there until the next read.
- R3: The transmit FIFO holds 8 bytes in first-in first-out order. `eng_tx_data_o` shows the oldest byte, and `eng_tx_pop_i` removes it. A DATA write while the FIFO is full is discarded.
- R4: The receive FIFO holds 8 bytes in order. Each DATA read pops one byte. A DATA read while the FIFO is empty returns 0 and sets ERR bit 0 (read overrun). An engine push while the FIFO is full is discarded and also sets ERR bit 0.
- R5: STAT2 holds live flags: bit 0 bus idle, bit 1 transmit FIFO full, bit 2 transmit FIFO empty, bit 3 receive FIFO empty, bit 4 receive FIFO full.
- R6: ERR bit 1 (write underrun) sets when the engine pops an empty transmit FIFO. ERR bit 2 (bus error) sets on `eng_bus_err_i`. Writing 1 to an ERR bit clears it. A set in the same cycle as a clear wins.
- R7: STAT1 bit 0 is a sticky end-of-frame flag. `eng_eof_i` sets it, and writing 1 to it clears it.
- R8: `irq_o` = CTRL bit 4 (master enable) AND ((IEN1 bit 0 AND any ERR bit) OR (IEN2 bit 0 AND transmit FIFO empty) OR (IEN2 bit 1 AND receive FIFO full)). The bus-idle flag never affects `irq_o`.
- R9: While CTRL bit 2 (FIFO reset) is set, both FIFOs stay empty and DATA writes and engine pushes are lost. Normal operation returns only after software writes the bit back to 0.
- R10: CTRL bit 0 drives `pd_o`. While it is set, `tx_en_o` is 0 whatever the value of CTRL bit 3 (transmit enable).
- R11: Writing CTRL with bit 1 set resets every register and both FIFOs to their defaults at that same edge, so CTRL reads back 0. `soft_rst_o` is high for exactly the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 4 | Register address |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| eng_tx_pop_i | input | 1 | Engine removes the oldest transmit byte |
| eng_tx_data_o | output | 8 | Oldest transmit byte |
| eng_tx_empty_o | output | 1 | Transmit FIFO empty |
| eng_rx_push_i | input | 1 | Engine stores a received byte |
| eng_rx_data_i | input | 8 | Received byte |
| eng_eof_i | input | 1 | Transaction complete pulse |
| eng_bus_err_i | input | 1 | Bus error pulse |
| bus_idle_i | input | 1 | Live bus idle indication |
| pd_o | output | 1 | Power-down to engine |
| soft_rst_o | output | 1 | One-cycle soft reset pulse |
| fifo_rst_o | output | 1 | FIFO reset level |
| tx_en_o | output | 1 | Transmit enable, gated by power-down |
| bit_time_o | output | 16 | Bit-time divisor |
| irq_o | output | 1 | Combined interrupt |

## Verification
Two situations are hard to reach from the ports: a flag being set and cleared in the same cycle, and FIFO overflow on both sides. For the first, the bench drives the engine bus-error pulse on the same edge as a write-one-to-clear of that bit, then reads ERR. For the second, it writes nine bytes into the transmit FIFO and pushes nine bytes into the receive FIFO. It then drains both FIFOs and checks that the ninth byte is missing and that the overrun and underrun flags are set. The FIFO-reset hold is exercised by writing data while the bit is set, then checking that nothing lands after the bit is cleared.

// File: rtl/peci_rf_pkg.sv
package peci_rf_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned AW = 4;

  localparam logic [AW-1:0] A_DATA  = 4'd0;
  localparam logic [AW-1:0] A_CTRL  = 4'd1;
  localparam logic [AW-1:0] A_STAT1 = 4'd2;
  localparam logic [AW-1:0] A_STAT2 = 4'd3;
  localparam logic [AW-1:0] A_ERR   = 4'd4;
  localparam logic [AW-1:0] A_IEN1  = 4'd5;
  localparam logic [AW-1:0] A_IEN2  = 4'd6;
  localparam logic [AW-1:0] A_BTLO  = 4'd7;
  localparam logic [AW-1:0] A_BTHI  = 4'd8;

  localparam int unsigned C_PD   = 0;
  localparam int unsigned C_SRST = 1;
  localparam int unsigned C_FRST = 2;
  localparam int unsigned C_TXEN = 3;
  localparam int unsigned C_MIEN = 4;

  localparam int unsigned NERR  = 3;
  localparam int unsigned E_ROV = 0;
  localparam int unsigned E_WUN = 1;
  localparam int unsigned E_BUS = 2;
endpackage

// File: rtl/peci_byte_fifo.sv
module peci_byte_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o && !clr_i;
  assign do_pop  = pop_i && !empty_o && !clr_i;
  assign rdata_o = mem[rp_q];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= nxt(wp_q);
      if (do_pop)  rp_q <= nxt(rp_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wp_q] <= wdata_i;
  end

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  assert_full_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !clr_i) |=> full_o);
  assert_clr_empty_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> empty_o);
endmodule

// File: rtl/peci_w1c_flags.sv
module peci_w1c_flags #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         srst_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (srst_i) q_o <= '0;
    else             q_o <= (q_o & ~clr_i) | set_i;  // set wins
  end

  assert_w1c_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!srst_i && |(clr_i & ~set_i)) |=> ((q_o & $past(clr_i & ~set_i)) == '0));
  assert_set_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!srst_i && |set_i) |=> ((q_o & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/peci_irq_merge.sv
module peci_irq_merge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mien_i,
  input  logic err_en_i,
  input  logic err_any_i,
  input  logic wfe_en_i,
  input  logic wfe_i,
  input  logic rff_en_i,
  input  logic rff_i,
  output logic irq_o
);
  logic src;
  assign src   = (err_en_i & err_any_i) | (wfe_en_i & wfe_i) | (rff_en_i & rff_i);
  assign irq_o = mien_i & src;

  assert_irq_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mien_i |-> !irq_o);
  assert_irq_src_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mien_i && err_en_i && err_any_i) |-> irq_o);
endmodule

// File: rtl/peci_host_regs.sv
module peci_host_regs
  import peci_rf_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          eng_tx_pop_i,
  output logic [DW-1:0] eng_tx_data_o,
  output logic          eng_tx_empty_o,
  input  logic          eng_rx_push_i,
  input  logic [DW-1:0] eng_rx_data_i,
  input  logic          eng_eof_i,
  input  logic          eng_bus_err_i,
  input  logic          bus_idle_i,
  output logic          pd_o,
  output logic          soft_rst_o,
  output logic          fifo_rst_o,
  output logic          tx_en_o,
  output logic [15:0]   bit_time_o,
  output logic          irq_o
);
  logic          pd_q, frst_q, txen_q, mien_q, ien1_q, srst_q;
  logic [1:0]    ien2_q;
  logic [DW-1:0] bt_lo_q, bt_hi_q, rx_head;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic          srst, wr_ctrl, wr_data, rd_data, fifo_clr;
  logic [NERR-1:0] err_q, err_set, err_clr;
  logic [0:0]    eof_q, eof_clr;

  assign wr_ctrl  = wr_en_i && (addr_i == A_CTRL);
  assign srst     = wr_ctrl && wdata_i[C_SRST];
  assign wr_data  = wr_en_i && (addr_i == A_DATA);
  assign rd_data  = rd_en_i && (addr_i == A_DATA);
  assign fifo_clr = frst_q || srst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {pd_q, frst_q, txen_q, mien_q, ien1_q} <= '0;
      ien2_q  <= '0;
      bt_lo_q <= '0;
      bt_hi_q <= '0;
      srst_q  <= 1'b0;
    end else begin
      srst_q <= srst;
      if (srst) begin
        {pd_q, frst_q, txen_q, mien_q, ien1_q} <= '0;
        ien2_q  <= '0;
        bt_lo_q <= '0;
        bt_hi_q <= '0;
      end else if (wr_en_i) begin
        unique case (addr_i)
          A_CTRL: begin
            pd_q   <= wdata_i[C_PD];
            frst_q <= wdata_i[C_FRST];
            txen_q <= wdata_i[C_TXEN];
            mien_q <= wdata_i[C_MIEN];
          end
          A_IEN1:  ien1_q  <= wdata_i[0];
          A_IEN2:  ien2_q  <= wdata_i[1:0];
          A_BTLO:  bt_lo_q <= wdata_i;
          A_BTHI:  bt_hi_q <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  peci_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(DW)) u_tx_fifo (
    .clk_i, .rst_ni, .clr_i(fifo_clr),
    .push_i(wr_data), .wdata_i(wdata_i),
    .pop_i(eng_tx_pop_i), .rdata_o(eng_tx_data_o),
    .full_o(tx_full), .empty_o(tx_empty)
  );

  peci_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(DW)) u_rx_fifo (
    .clk_i, .rst_ni, .clr_i(fifo_clr),
    .push_i(eng_rx_push_i), .wdata_i(eng_rx_data_i),
    .pop_i(rd_data), .rdata_o(rx_head),
    .full_o(rx_full), .empty_o(rx_empty)
  );

  always_comb begin
    err_set        = '0;
    err_set[E_ROV] = (rd_data && rx_empty) || (eng_rx_push_i && rx_full && !fifo_clr);
    err_set[E_WUN] = eng_tx_pop_i && tx_empty;
    err_set[E_BUS] = eng_bus_err_i;
  end
  assign err_clr = (wr_en_i && addr_i == A_ERR)   ? wdata_i[NERR-1:0] : '0;
  assign eof_clr = (wr_en_i && addr_i == A_STAT1) ? wdata_i[0:0]      : '0;

  peci_w1c_flags #(.N(NERR)) u_err (
    .clk_i, .rst_ni, .srst_i(srst), .set_i(err_set), .clr_i(err_clr), .q_o(err_q)
  );
  peci_w1c_flags #(.N(1)) u_eof (
    .clk_i, .rst_ni, .srst_i(srst), .set_i(eng_eof_i), .clr_i(eof_clr), .q_o(eof_q)
  );

  peci_irq_merge u_irq (
    .clk_i, .rst_ni,
    .mien_i(mien_q), .err_en_i(ien1_q), .err_any_i(|err_q),
    .wfe_en_i(ien2_q[0]), .wfe_i(tx_empty),
    .rff_en_i(ien2_q[1]), .rff_i(rx_full),
    .irq_o(irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (rd_en_i) begin
      unique case (addr_i)
        A_DATA:  rdata_o <= rx_empty ? '0 : rx_head;
        A_CTRL:  rdata_o <= {3'b0, mien_q, txen_q, frst_q, 1'b0, pd_q};
        A_STAT1: rdata_o <= {7'b0, eof_q};
        A_STAT2: rdata_o <= {3'b0, rx_full, rx_empty, tx_empty, tx_full, bus_idle_i};
        A_ERR:   rdata_o <= {{(DW-NERR){1'b0}}, err_q};
        A_IEN1:  rdata_o <= {7'b0, ien1_q};
        A_IEN2:  rdata_o <= {6'b0, ien2_q};
        A_BTLO:  rdata_o <= bt_lo_q;
        A_BTHI:  rdata_o <= bt_hi_q;
        default: rdata_o <= '0;
      endcase
    end
  end

  assign pd_o           = pd_q;
  assign soft_rst_o     = srst_q;
  assign fifo_rst_o     = frst_q;
  assign tx_en_o        = txen_q & ~pd_q;
  assign bit_time_o     = {bt_hi_q, bt_lo_q};
  assign eng_tx_empty_o = tx_empty;

  assert_pd_blocks_tx_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl && wdata_i[C_PD]) |=> !tx_en_o);
  assert_srst_defaults_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst |=> (soft_rst_o && bit_time_o == '0 && !pd_o && !irq_o && eng_tx_empty_o));
  assert_srst_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (soft_rst_o && !$past(srst)) |-> 1'b0);
  assert_rd_empty_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data && rx_empty && !srst) |=> (rdata_o == '0 && err_q[E_ROV]));
endmodule

// File: tb/peci_host_regs_tb_top.sv
module peci_host_regs_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic       we = 1'b0, re = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic       tx_pop = 1'b0, rx_push = 1'b0, eof = 1'b0, berr = 1'b0, idle = 1'b1;
  logic [7:0] rx_data = '0, tx_data;
  logic       tx_empty, pd, srst, frst, txen, irq;
  logic [15:0] bt;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  peci_host_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(we), .rd_en_i(re),
    .wdata_i(wdata), .rdata_o(rdata), .eng_tx_pop_i(tx_pop), .eng_tx_data_o(tx_data),
    .eng_tx_empty_o(tx_empty), .eng_rx_push_i(rx_push), .eng_rx_data_i(rx_data),
    .eng_eof_i(eof), .eng_bus_err_i(berr), .bus_idle_i(idle), .pd_o(pd),
    .soft_rst_o(srst), .fifo_rst_o(frst), .tx_en_o(txen), .bit_time_o(bt), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; re = 1'b1;
    @(negedge clk); re = 1'b0; d = rdata;
  endtask

  task automatic rdchk(input string req, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, {8'h0, v}, {8'h0, exp});
  endtask

  task automatic pop_tx();
    @(negedge clk); tx_pop = 1'b1;
    @(negedge clk); tx_pop = 1'b0;
  endtask

  task automatic push_rx(input logic [7:0] d);
    @(negedge clk); rx_data = d; rx_push = 1'b1;
    @(negedge clk); rx_push = 1'b0;
  endtask

  // {write, addr, data, expected read}
  localparam logic [20:0] VEC [13] = '{
    {1'b1, 4'd7, 8'hE0, 8'h00},
    {1'b1, 4'd8, 8'h01, 8'h00},
    {1'b0, 4'd7, 8'h00, 8'hE0},
    {1'b0, 4'd8, 8'h00, 8'h01},
    {1'b1, 4'd0, 8'hA5, 8'h00},
    {1'b0, 4'd3, 8'h00, 8'h09},
    {1'b1, 4'd6, 8'h01, 8'h00},
    {1'b0, 4'd6, 8'h00, 8'h01},
    {1'b0, 4'd4, 8'h00, 8'h00},
    {1'b0, 4'd0, 8'h00, 8'h00},
    {1'b0, 4'd4, 8'h00, 8'h01},
    {1'b1, 4'd4, 8'h01, 8'h00},
    {1'b0, 4'd4, 8'h00, 8'h00}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 bit_time", bt, 16'h0);
    chk("R1 irq", {15'h0, irq}, 16'h0);
    rdchk("R1 ctrl", 4'd1, 8'h00);
    rdchk("R1 stat1", 4'd2, 8'h00);
    rdchk("R1 stat2", 4'd3, 8'h0D);
    rdchk("R1 err", 4'd4, 8'h00);

    // R2/R4/R5/R6 vector table
    for (int i = 0; i < 13; i++) begin
      if (VEC[i][20]) wr(VEC[i][19:16], VEC[i][15:8]);
      else rdchk($sformatf("R2 vec%0d", i), VEC[i][19:16], VEC[i][7:0]);
    end
    chk("R2 bit_time_o", bt, 16'h01E0);

    // R3 transmit FIFO fill, overflow drop, order
    wr(4'd6, 8'h00);
    for (int i = 1; i <= 8; i++) wr(4'd0, 8'(i));
    rdchk("R5 stat2 tx full", 4'd3, 8'h0B);
    for (int i = 0; i < 8; i++) begin
      chk("R3 tx order", {8'h0, tx_data}, {8'h0, (i == 0) ? 8'hA5 : 8'(i)});
      pop_tx();
    end
    chk("R3 tx empty", {15'h0, tx_empty}, 16'h1);
    pop_tx();
    rdchk("R6 underrun", 4'd4, 8'h02);
    rdchk("R5 stat2 idle empties", 4'd3, 8'h0D);

    // R8 interrupt merge
    wr(4'd5, 8'h01);
    chk("R8 no master", {15'h0, irq}, 16'h0);
    wr(4'd1, 8'h10);
    chk("R8 err irq", {15'h0, irq}, 16'h1);
    @(negedge clk); idle = 1'b0;
    @(negedge clk);
    chk("R8 idle no effect", {15'h0, irq}, 16'h1);
    rdchk("R5 idle low", 4'd3, 8'h0C);
    idle = 1'b1;
    wr(4'd4, 8'h02);
    chk("R8 err cleared", {15'h0, irq}, 16'h0);
    @(negedge clk); idle = 1'b0;
    @(negedge clk);
    chk("R8 idle no irq", {15'h0, irq}, 16'h0);
    idle = 1'b1;
    wr(4'd6, 8'h01);
    chk("R8 wfe irq", {15'h0, irq}, 16'h1);
    wr(4'd6, 8'h00);

    // R4 receive FIFO
    push_rx(8'h11); push_rx(8'h22); push_rx(8'h33);
    rdchk("R4 rx 0", 4'd0, 8'h11);
    rdchk("R4 rx 1", 4'd0, 8'h22);
    rdchk("R4 rx 2", 4'd0, 8'h33);
    for (int i = 0; i < 8; i++) push_rx(8'h40 + 8'(i));
    rdchk("R5 rx full", 4'd3, 8'h15);
    wr(4'd6, 8'h02);
    chk("R8 rff irq", {15'h0, irq}, 16'h1);
    push_rx(8'h99);
    rdchk("R4 push overrun", 4'd4, 8'h01);
    for (int i = 0; i < 8; i++) rdchk("R4 rx drain", 4'd0, 8'h40 + 8'(i));
    rdchk("R4 rx empty", 4'd3, 8'h0D);
    wr(4'd4, 8'h01);
    wr(4'd6, 8'h00);
    chk("R8 idle off", {15'h0, irq}, 16'h0);

    // R6 set wins over clear in same cycle
    @(negedge clk); addr = 4'd4; wdata = 8'h04; we = 1'b1; berr = 1'b1;
    @(negedge clk); we = 1'b0; berr = 1'b0;
    rdchk("R6 set wins", 4'd4, 8'h04);
    wr(4'd4, 8'h04);
    rdchk("R6 bus err cleared", 4'd4, 8'h00);

    // R7 end of frame
    @(negedge clk); eof = 1'b1;
    @(negedge clk); eof = 1'b0;
    repeat (2) @(negedge clk);
    rdchk("R7 eof sticky", 4'd2, 8'h01);
    wr(4'd2, 8'h01);
    rdchk("R7 eof cleared", 4'd2, 8'h00);

    // R9 FIFO reset hold
    wr(4'd0, 8'h77);
    push_rx(8'h88);
    wr(4'd1, 8'h14);
    chk("R9 fifo_rst_o", {15'h0, frst}, 16'h1);
    rdchk("R9 held empty", 4'd3, 8'h0D);
    wr(4'd0, 8'h55);
    push_rx(8'h56);
    rdchk("R9 writes lost", 4'd3, 8'h0D);
    wr(4'd1, 8'h10);
    rdchk("R9 still empty", 4'd3, 8'h0D);
    wr(4'd0, 8'h66);
    chk("R9 resume", {8'h0, tx_data}, 16'h0066);

    // R10 power-down gating
    wr(4'd1, 8'h19);
    chk("R10 pd_o", {15'h0, pd}, 16'h1);
    chk("R10 tx_en gated", {15'h0, txen}, 16'h0);
    rdchk("R10 ctrl readback", 4'd1, 8'h19);
    wr(4'd1, 8'h18);
    chk("R10 tx_en on", {15'h0, txen}, 16'h1);

    // R11 soft reset
    wr(4'd7, 8'h12);
    wr(4'd1, 8'h02);
    chk("R11 pulse", {15'h0, srst}, 16'h1);
    @(negedge clk);
    chk("R11 pulse ends", {15'h0, srst}, 16'h0);
    chk("R11 bit_time", bt, 16'h0);
    chk("R11 tx_en", {15'h0, txen}, 16'h0);
    rdchk("R11 ctrl", 4'd1, 8'h00);
    rdchk("R11 stat2", 4'd3, 8'h0D);

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule